// File: doc/BRIEF.md
# Addressed serial command framer

This block is the slave-side front end of a four-channel digital potentiometer controller. It watches a four-wire serial link (clock, data in, data out, active-low select) together with an active-low pause line. All of these are oversampled in the system clock domain. A frame opens on a falling edge of select. The block takes in an address byte and an instruction byte, and for some commands a third byte. It then passes decoded fields and one-cycle strobes to a register controller that sits next to it. Read data from that controller is shifted back out on the serial output.

The address byte must carry a fixed 4-bit device type and two zero bits. Its low two bits must equal the strap inputs of this device, so up to four devices can share one link. The opcode in the instruction byte sets the frame length. Writes and reads take three bytes. The four transfer commands take two bytes. Any other opcode makes the rest of the frame ignored. Write and transfer commands are committed only when select rises after a complete frame. Read commands raise a read request as soon as the instruction byte is in.

The control path is a single state machine with six states:
- `ST_IDLE`: no frame is open.
- `ST_ADDR`: the address byte is being received.
- `ST_INSTR`: the instruction byte is being received.
- `ST_DATA`: the third byte is being received.
- `ST_DONE`: the frame is complete, and further bytes are ignored.
- `ST_SKIP`: the frame has been rejected.

Its transitions are:
- `ST_IDLE` goes to `ST_ADDR` on a select falling edge.
- `ST_ADDR` goes to `ST_INSTR` when the address matches, or to `ST_SKIP` when it does not.
- `ST_INSTR` goes to `ST_DATA` for a three-byte opcode, to `ST_DONE` for a two-byte opcode, or to `ST_SKIP` for an unknown opcode.
- `ST_DATA` goes to `ST_DONE` once the third byte is complete.
- Every state other than `ST_IDLE` returns to `ST_IDLE` when select rises.

The pause is a separate held flag beside the state machine. While it is set, the state machine does not advance.

Top module: `cmd_framer`

## Requirements
- R1: While reset is asserted, `so_en`, `so_d`, `rd_req` and `cmd_valid` are all low.
- R2: The first byte of a frame is accepted only if bits 7..4 equal 4'b0101, bits 3..2 equal 2'b00, and bits 1..0 equal `strap`. Any other first byte makes the rest of the frame ignored: no strobe is produced and `so_en` stays low.
- R3: In the second byte, bits 7..4 are the opcode, bits 3..2 are the register index, and bits 1..0 are the wiper index. These appear on `cmd_op`, `cmd_dreg` and `cmd_wiper` together with every strobe.
- R4: The write-wiper opcode (4'b1010) and the write-register opcode (4'b1100) take a third byte, received MSB first, which appears on `cmd_data`. One `cmd_valid` pulse follows the rise of select.
- R5: The transfer opcodes 4'b1101, 4'b1110, 4'b0001 and 4'b1000 complete after two bytes. One `cmd_valid` pulse follows the rise of select.
- R6: If select rises before the byte count that the opcode requires, no `cmd_valid` is produced.
- R7: The read opcodes (read wiper 4'b1001, read register 4'b1011, read status 4'b0101) give one `rd_req` pulse after the instruction byte, with `rd_data` sampled during that pulse. That byte is shifted out on `so_d`, MSB first, one bit per falling SCK edge. The first bit comes on the falling edge that follows the last rising edge of the instruction byte. Reads never give `cmd_valid`.
- R8: `so_en` is low while select is high and during the address byte. It is high from a matched address until select rises, except when the frame is paused or rejected.
- R9: When the pause input goes low while SCK is low, the frame is held. While held, `so_en` is low and SCK edges and SI are ignored. When the pause input returns high while SCK is low, the frame continues where it stopped.
- R10: Bytes after a complete frame are ignored. `cmd_data` keeps the third byte, only one strobe is produced, and after a read byte `so_d` shifts out zeros.
- R11: A frame starts only on a falling edge of select. If select is already low when reset is released, no command is taken until select has gone high and low again.
- R12: Opcodes outside the nine listed above produce no strobe, and `so_en` drops once the instruction byte is in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, asynchronous |
| si | input | 1 | Serial data in, sampled on SCK rise |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| hold_n | input | 1 | Active-low pause, asynchronous |
| strap | input | 2 | Device address straps, static |
| rd_data | input | 8 | Read byte from the register controller, sampled while `rd_req` is high |
| so_d | output | 1 | Serial data out value |
| so_en | output | 1 | Output enable for the serial data out pad (low means high impedance) |
| rd_req | output | 1 | One-cycle read request |
| cmd_valid | output | 1 | One-cycle commit strobe for write and transfer commands |
| cmd_op | output | 4 | Decoded opcode |
| cmd_dreg | output | 2 | Decoded register index |
| cmd_wiper | output | 2 | Decoded wiper index |
| cmd_data | output | 8 | Third byte of a write command |

## Verification
A bit counter that slips or a wrong state shows up within the same frame. The decoded fields come out shifted, the strobe count is off by one, or `so_en` has the wrong value at the sample point in the middle of the instruction byte. A broken address filter or length decode is exposed by sweeping every address byte and every opcode, because each one predicts exactly one strobe or none. A pause that does not freeze the machine picks up the toggled SI bits during the pause and corrupts the committed byte.

// File: rtl/framer_pkg.sv
`timescale 1ns/1ps
package framer_pkg;

    localparam int BYTE_W  = 8;
    localparam int OP_W    = 4;
    localparam int IDX_W   = 2;
    localparam int OP_LSB  = 2 * IDX_W;
    localparam int REG_LSB = IDX_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_INSTR,
        ST_DATA,
        ST_DONE,
        ST_SKIP
    } frame_state_t;

    typedef enum logic [1:0] {
        LEN_NONE,
        LEN_TWO,
        LEN_THREE
    } cmd_len_t;

    localparam logic [OP_W-1:0] OPC_RD_WIPER     = 4'b1001;
    localparam logic [OP_W-1:0] OPC_WR_WIPER     = 4'b1010;
    localparam logic [OP_W-1:0] OPC_RD_REG       = 4'b1011;
    localparam logic [OP_W-1:0] OPC_WR_REG       = 4'b1100;
    localparam logic [OP_W-1:0] OPC_RD_STATUS    = 4'b0101;
    localparam logic [OP_W-1:0] OPC_REG_TO_WIPER = 4'b1101;
    localparam logic [OP_W-1:0] OPC_WIPER_TO_REG = 4'b1110;
    localparam logic [OP_W-1:0] OPC_ALL_TO_WIPER = 4'b0001;
    localparam logic [OP_W-1:0] OPC_ALL_TO_REG   = 4'b1000;

    function automatic cmd_len_t op_length(input logic [OP_W-1:0] op);
        cmd_len_t len;
        case (op)
            OPC_RD_WIPER, OPC_WR_WIPER, OPC_RD_REG,
            OPC_WR_REG, OPC_RD_STATUS:             len = LEN_THREE;
            OPC_REG_TO_WIPER, OPC_WIPER_TO_REG,
            OPC_ALL_TO_WIPER, OPC_ALL_TO_REG:      len = LEN_TWO;
            default:                               len = LEN_NONE;
        endcase
        return len;
    endfunction

    function automatic logic op_reads(input logic [OP_W-1:0] op);
        return (op == OPC_RD_WIPER) || (op == OPC_RD_REG) || (op == OPC_RD_STATUS);
    endfunction

    function automatic logic op_commits(input logic [OP_W-1:0] op);
        return (op_length(op) != LEN_NONE) && !op_reads(op);
    endfunction

endpackage

// File: rtl/sig_sync.sv
`timescale 1ns/1ps
module sig_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;
    logic [STAGES-1:0][W-1:0] pipe_nxt;

    generate
        if (STAGES == 1) begin : g_single
            assign pipe_nxt = d;
        end else begin : g_chain
            assign pipe_nxt = {pipe[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe <= pipe_nxt;
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/serial_frontend.sv
`timescale 1ns/1ps
module serial_frontend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic si,
    input  logic cs_n,
    input  logic hold_n,
    output logic si_s,
    output logic cs_act,
    output logic cs_start,
    output logic held,
    output logic sck_rise,
    output logic sck_fall
);
    localparam int LINES = 4;
    // line order {hold_n, cs_n, si, sck}; select resets to active so that a
    // select already low at reset release never looks like a fresh edge
    localparam logic [LINES-1:0] LINE_RST = 4'b1000;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] sync_lines;
    logic             sck_s;
    logic             hold_s;
    logic             sck_prev;
    logic             act_prev;
    logic             held_q;
    logic             accept;

    assign raw_lines = {hold_n, cs_n, si, sck};

    sig_sync #(
        .W       (LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINE_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lines),
        .q     (sync_lines)
    );

    assign sck_s  = sync_lines[0];
    assign si_s   = sync_lines[1];
    assign cs_act = !sync_lines[2];
    assign hold_s = sync_lines[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            act_prev <= 1'b1;
            held_q   <= 1'b0;
        end else begin
            sck_prev <= sck_s;
            act_prev <= cs_act;
            if (!cs_act) begin
                held_q <= 1'b0;
            end else if (!sck_s) begin
                held_q <= !hold_s;
            end
        end
    end

    assign accept   = cs_act && hold_s && !held_q;
    assign cs_start = cs_act && !act_prev;
    assign sck_rise = accept && sck_s && !sck_prev;
    assign sck_fall = accept && !sck_s && sck_prev;
    assign held     = held_q;
endmodule

// File: rtl/cmd_frame_fsm.sv
`timescale 1ns/1ps
module cmd_frame_fsm
    import framer_pkg::*;
#(
    parameter int                TYPE_W   = 4,
    parameter int                STRAP_W  = 2,
    parameter logic [TYPE_W-1:0] DEV_TYPE = 4'b0101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_rise,
    input  logic               si_s,
    input  logic               cs_act,
    input  logic               cs_start,
    input  logic [STRAP_W-1:0] strap,
    output frame_state_t       state,
    output logic               addressed,
    output logic [OP_W-1:0]    cmd_op,
    output logic [IDX_W-1:0]   cmd_dreg,
    output logic [IDX_W-1:0]   cmd_wiper,
    output logic [BYTE_W-1:0]  cmd_data,
    output logic               rd_req,
    output logic               cmd_valid
);
    localparam int               PAD_W    = BYTE_W - TYPE_W - STRAP_W;
    localparam int               CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    frame_state_t             state_q;
    frame_state_t             state_d;
    logic [CNT_W-1:0]         bit_cnt;
    logic [BYTE_W-2:0]        shreg;
    logic [BYTE_W-1:0]        byte_val;
    logic                     collecting;
    logic                     byte_done;
    logic                     addr_ok;
    cmd_len_t                 new_len;
    logic [OP_W-1:0]          op_q;
    logic [IDX_W-1:0]         dreg_q;
    logic [IDX_W-1:0]         wiper_q;
    logic [BYTE_W-1:0]        data_q;
    logic                     rd_req_q;
    logic                     valid_q;

    assign byte_val   = {shreg, si_s};
    assign collecting = (state_q == ST_ADDR) || (state_q == ST_INSTR) || (state_q == ST_DATA);
    assign byte_done  = collecting && sck_rise && (bit_cnt == LAST_BIT);
    assign addr_ok    = (byte_val[BYTE_W-1 -: TYPE_W] == DEV_TYPE)
                     && (byte_val[STRAP_W +: PAD_W] == '0)
                     && (byte_val[STRAP_W-1:0] == strap);
    assign new_len    = op_length(byte_val[OP_LSB +: OP_W]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_start) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (!cs_act)        state_d = ST_IDLE;
                else if (byte_done) state_d = addr_ok ? ST_INSTR : ST_SKIP;
            end
            ST_INSTR: begin
                if (!cs_act) begin
                    state_d = ST_IDLE;
                end else if (byte_done) begin
                    unique case (new_len)
                        LEN_THREE: state_d = ST_DATA;
                        LEN_TWO:   state_d = ST_DONE;
                        default:   state_d = ST_SKIP;
                    endcase
                end
            end
            ST_DATA: begin
                if (!cs_act)        state_d = ST_IDLE;
                else if (byte_done) state_d = ST_DONE;
            end
            ST_DONE, ST_SKIP: begin
                if (!cs_act) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // byte assembly and field capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            op_q    <= '0;
            dreg_q  <= '0;
            wiper_q <= '0;
            data_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            bit_cnt <= '0;
        end else if (collecting && sck_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= byte_val[BYTE_W-2:0];
            if (byte_done && (state_q == ST_INSTR)) begin
                op_q    <= byte_val[OP_LSB +: OP_W];
                dreg_q  <= byte_val[REG_LSB +: IDX_W];
                wiper_q <= byte_val[IDX_W-1:0];
            end
            if (byte_done && (state_q == ST_DATA)) begin
                data_q <= byte_val;
            end
        end
    end

    // strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_req_q <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            rd_req_q <= byte_done && (state_q == ST_INSTR)
                        && op_reads(byte_val[OP_LSB +: OP_W]);
            valid_q  <= (state_q == ST_DONE) && !cs_act && op_commits(op_q);
        end
    end

    assign state     = state_q;
    assign addressed = (state_q == ST_INSTR) || (state_q == ST_DATA) || (state_q == ST_DONE);
    assign cmd_op    = op_q;
    assign cmd_dreg  = dreg_q;
    assign cmd_wiper = wiper_q;
    assign cmd_data  = data_q;
    assign rd_req    = rd_req_q;
    assign cmd_valid = valid_q;
endmodule

// File: rtl/so_shifter.sv
`timescale 1ns/1ps
module so_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         so
);
    logic [W-1:0] buf_q;
    logic         so_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            so_q  <= 1'b0;
        end else if (clear) begin
            buf_q <= '0;
            so_q  <= 1'b0;
        end else if (load) begin
            buf_q <= load_val;
        end else if (shift) begin
            so_q  <= buf_q[W-1];
            buf_q <= {buf_q[W-2:0], 1'b0};
        end
    end

    assign so = so_q;
endmodule

// File: rtl/cmd_framer.sv
`timescale 1ns/1ps
module cmd_framer
    import framer_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                TYPE_W      = 4,
    parameter int                STRAP_W     = 2,
    parameter logic [TYPE_W-1:0] DEV_TYPE    = 4'b0101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               si,
    input  logic               cs_n,
    input  logic               hold_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               so_d,
    output logic               so_en,
    output logic               rd_req,
    output logic               cmd_valid,
    output logic [OP_W-1:0]    cmd_op,
    output logic [IDX_W-1:0]   cmd_dreg,
    output logic [IDX_W-1:0]   cmd_wiper,
    output logic [BYTE_W-1:0]  cmd_data
);
    logic         si_s;
    logic         cs_act;
    logic         cs_start;
    logic         held;
    logic         sck_rise;
    logic         sck_fall;
    logic         addressed;
    frame_state_t fsm_state;

    serial_frontend #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .si       (si),
        .cs_n     (cs_n),
        .hold_n   (hold_n),
        .si_s     (si_s),
        .cs_act   (cs_act),
        .cs_start (cs_start),
        .held     (held),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    cmd_frame_fsm #(
        .TYPE_W   (TYPE_W),
        .STRAP_W  (STRAP_W),
        .DEV_TYPE (DEV_TYPE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .si_s      (si_s),
        .cs_act    (cs_act),
        .cs_start  (cs_start),
        .strap     (strap),
        .state     (fsm_state),
        .addressed (addressed),
        .cmd_op    (cmd_op),
        .cmd_dreg  (cmd_dreg),
        .cmd_wiper (cmd_wiper),
        .cmd_data  (cmd_data),
        .rd_req    (rd_req),
        .cmd_valid (cmd_valid)
    );

    so_shifter #(
        .W (BYTE_W)
    ) u_so (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!cs_act),
        .load     (rd_req),
        .load_val (rd_data),
        .shift    (sck_fall),
        .so       (so_d)
    );

    assign so_en = addressed && !held;
endmodule

// File: rtl/cmd_framer_checker.sv
`timescale 1ns/1ps
module cmd_framer_checker
    import framer_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         cs_act,
    input logic         held,
    input frame_state_t state,
    input logic         so_en,
    input logic         rd_req,
    input logic         cmd_valid
);
    // R7: a read never commits, and its request lasts one cycle
    p_read_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !cmd_valid);
    p_read_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    // R4: the commit strobe is one cycle
    p_commit_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R6: a commit only follows a deselect
    p_commit_after_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$past(cs_act));
    // R8: deselect releases the output
    p_deselect_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !so_en);
    // R9: a held frame neither drives nor advances
    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !so_en);
    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (held && cs_act) |=> $stable(state));
    // R2: a rejected frame stays silent
    p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!so_en && !rd_req));
endmodule

bind cmd_framer cmd_framer_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .held      (held),
    .state     (fsm_state),
    .so_en     (so_en),
    .rd_req    (rd_req),
    .cmd_valid (cmd_valid)
);

// File: tb/cmd_framer_test.sv
`timescale 1ns/1ps
module cmd_framer_test;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sck, si, cs_n, hold_n;
    logic [1:0] strap;
    logic [7:0] rd_data;
    logic       so_d, so_en, rd_req, cmd_valid;
    logic [3:0] cmd_op;
    logic [1:0] cmd_dreg, cmd_wiper;
    logic [7:0] cmd_data;

    always #2.5 clk = ~clk;

    cmd_framer uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
        .strap(strap), .rd_data(rd_data), .so_d(so_d), .so_en(so_en), .rd_req(rd_req),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dreg(cmd_dreg),
        .cmd_wiper(cmd_wiper), .cmd_data(cmd_data)
    );

    // register controller model: read byte derived from the decoded fields
    assign rd_data = {cmd_op, cmd_dreg, cmd_wiper} ^ 8'h5A;

    int checks = 0;
    int errors = 0;
    int n_valid = 0;
    int n_rd = 0;
    logic [3:0] cap_op = '0;
    logic [1:0] cap_dreg = '0, cap_wiper = '0;
    logic [7:0] cap_data = '0;
    logic [7:0] so_b2, so_b3;
    logic en_addr, en_instr, en_data, en_hold, en_hold2, en_after;

    always @(negedge clk) begin
        if (cmd_valid) begin
            n_valid++;
            cap_op    = cmd_op;
            cap_dreg  = cmd_dreg;
            cap_wiper = cmd_wiper;
            cap_data  = cmd_data;
        end
        if (rd_req) n_rd++;
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int is_read(input logic [3:0] op);
        return (op == 4'h9 || op == 4'hB || op == 4'h5) ? 1 : 0;
    endfunction
    function automatic int is_commit(input logic [3:0] op);
        return (op == 4'hA || op == 4'hC || op == 4'hD || op == 4'hE ||
                op == 4'h1 || op == 4'h8) ? 1 : 0;
    endfunction

    task automatic frame(input logic [31:0] bits, input int nbits, input int hold_at);
        cs_n = 1'b0;
        waitc(H);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0;
            si  = bits[31-i];
            waitc(H);
            if (i == hold_at) begin
                hold_n = 1'b0;
                waitc(H);
                en_hold = so_en;
                for (int k = 0; k < 3; k++) begin
                    si = ~si; sck = 1'b1; waitc(H);
                    sck = 1'b0; waitc(H);
                end
                en_hold2 = so_en;
                hold_n = 1'b1;
                si = bits[31-i];
                waitc(H);
            end
            if (i >= 16 && i < 24) so_b2[23-i] = so_d;
            if (i >= 24)           so_b3[31-i] = so_d;
            if (i == 3)  en_addr  = so_en;
            if (i == 12) en_instr = so_en;
            if (i == 20) en_data  = so_en;
            sck = 1'b1;
            waitc(H);
        end
        sck = 1'b0;
        waitc(H);
        cs_n = 1'b1;
        waitc(2 * H);
        en_after = so_en;
    endtask

    logic [7:0] adr;
    int v0, r0;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; sck = 1'b0; si = 1'b0; cs_n = 1'b0; hold_n = 1'b1; strap = 2'b00;
        waitc(5);
        chk("R1 so_en", so_en, 0);
        chk("R1 so_d", so_d, 0);
        chk("R1 rd_req", rd_req, 0);
        chk("R1 cmd_valid", cmd_valid, 0);
        rst_n = 1'b1;
        waitc(10);

        // R11: select low since reset, no falling edge
        v0 = n_valid;
        frame({8'h50, 8'hD6, 16'h0}, 16, -1);
        chk("R11 no start without select edge", n_valid - v0, 0);
        v0 = n_valid;
        frame({8'h50, 8'hD6, 16'h0}, 16, -1);
        chk("R11 start after select edge", n_valid - v0, 1);

        // R2 / R8: every address byte with strap 2'b10
        strap = 2'b10;
        for (int a = 0; a < 256; a++) begin
            v0 = n_valid;
            frame({8'(a), 8'hD6, 16'h0}, 16, -1);
            chk("R2 address filter", n_valid - v0, (a == 8'h52) ? 1 : 0);
            chk("R8 so_en after address", en_instr, (a == 8'h52) ? 1 : 0);
            chk("R8 so_en during address", en_addr, 0);
        end
        chk("R8 so_en after deselect", en_after, 0);

        // R2: strap values
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            v0 = n_valid;
            frame({4'h5, 2'b00, 2'(s), 8'hD6, 16'h0}, 16, -1);
            chk("R2 strap match", n_valid - v0, 1);
            v0 = n_valid;
            frame({4'h5, 2'b00, 2'(s ^ 1), 8'hD6, 16'h0}, 16, -1);
            chk("R2 strap mismatch", n_valid - v0, 0);
            v0 = n_valid;
            frame({4'h5, 2'b01, 2'(s), 8'hD6, 16'h0}, 16, -1);
            chk("R2 pad bits nonzero", n_valid - v0, 0);
        end

        strap = 2'b01;
        adr = 8'h51;

        // R5 / R3: two-byte transfers, all field values
        for (int o = 0; o < 4; o++) begin
            logic [3:0] op;
            op = (o == 0) ? 4'hD : (o == 1) ? 4'hE : (o == 2) ? 4'h1 : 4'h8;
            for (int f = 0; f < 16; f++) begin
                v0 = n_valid;
                frame({adr, op, 4'(f), 16'h0}, 16, -1);
                chk("R5 transfer commit", n_valid - v0, 1);
                chk("R3 opcode field", cap_op, op);
                chk("R3 register field", cap_dreg, f / 4);
                chk("R3 wiper field", cap_wiper, f % 4);
            end
        end

        // R4: three-byte writes
        for (int k = 0; k < 8; k++) begin
            logic [7:0] d;
            logic [3:0] op;
            d  = 8'((k * 37 + 11) % 256);
            op = (k % 2 == 0) ? 4'hA : 4'hC;
            v0 = n_valid;
            frame({adr, op, 2'(k), 2'(3 - k % 4), d, 8'h00}, 24, -1);
            chk("R4 write commit", n_valid - v0, 1);
            chk("R4 write data", cap_data, d);
            chk("R4 write opcode", cap_op, op);
        end

        // R10: trailing byte after a write
        v0 = n_valid;
        frame({adr, 8'hA2, 8'h96, 8'h69}, 32, -1);
        chk("R10 single strobe", n_valid - v0, 1);
        chk("R10 data kept", cap_data, 8'h96);

        // R6: truncated frames
        v0 = n_valid;
        frame({adr, 8'hC5, 16'h0}, 16, -1);
        chk("R6 write cut after two bytes", n_valid - v0, 0);
        frame({adr, 8'hC5, 8'hF0, 8'h0}, 21, -1);
        chk("R6 write cut mid third byte", n_valid - v0, 0);
        frame({adr, 8'hD6, 16'h0}, 12, -1);
        chk("R6 transfer cut mid second byte", n_valid - v0, 0);
        frame({adr, 24'h0}, 8, -1);
        chk("R6 address only", n_valid - v0, 0);

        // R7 / R10: reads
        for (int o = 0; o < 3; o++) begin
            logic [3:0] op;
            op = (o == 0) ? 4'h9 : (o == 1) ? 4'hB : 4'h5;
            for (int f = 0; f < 8; f++) begin
                logic [7:0] ins;
                ins = {op, 4'(f * 2 + 1)};
                v0 = n_valid;
                r0 = n_rd;
                frame({adr, ins, 8'hFF, 8'h00}, 32, -1);
                chk("R7 one read request", n_rd - r0, 1);
                chk("R7 read does not commit", n_valid - v0, 0);
                chk("R7 serial read byte", so_b2, ins ^ 8'h5A);
                chk("R10 zeros after read byte", so_b3, 0);
            end
        end

        // R9: pause in third byte and in instruction byte
        v0 = n_valid;
        frame({adr, 8'hA3, 8'hC3, 8'h00}, 24, 20);
        chk("R9 output released while held", en_hold, 0);
        chk("R9 output released after pulses", en_hold2, 0);
        chk("R9 commit after resume", n_valid - v0, 1);
        chk("R9 data unaffected by held SI", cap_data, 8'hC3);
        v0 = n_valid;
        frame({adr, 8'hC9, 8'h5E, 8'h00}, 24, 10);
        chk("R9 held in instruction byte", en_hold, 0);
        chk("R9 commit after resume", n_valid - v0, 1);
        chk("R9 opcode intact", cap_op, 4'hC);
        chk("R9 wiper intact", cap_wiper, 1);
        chk("R9 data intact", cap_data, 8'h5E);

        // R12: every opcode
        for (int o = 0; o < 16; o++) begin
            v0 = n_valid;
            r0 = n_rd;
            frame({adr, 4'(o), 4'b1001, 8'h3C, 8'h00}, 24, -1);
            chk("R12 commit by opcode", n_valid - v0, is_commit(4'(o)));
            chk("R12 read by opcode", n_rd - r0, is_read(4'(o)));
            chk("R12 so_en by opcode", en_data,
                (is_commit(4'(o)) + is_read(4'(o)) > 0) ? 1 : 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule